// File: doc/BRIEF.md
# Live-Register Save and Restore Sequencer

This block holds a live-register word with one bit for each general register. A set bit means that the register holds a value the current caller still needs. On procedure entry the block receives the callee's needed-register mask. It saves only the registers that are both live and needed, then the previous live word, and it widens the live word by the callee's mask. The matching exit command carries the same mask and undoes the entry. It reads the previous live word back first, recomputes which registers were saved, and writes them back into the register file.

Two extra commands handle the case where a caller will call the same routine many times. The spill-all command saves every live register and the live word, then clears the live word to zero. The refill command reverses a spill-all. In the optional tracking mode, every register write reported by the core sets that register's live bit, so software does not have to supply a mask.

The block drives a register-file port, which has a combinational read and a registered write, and a single-port stack memory, which has a one-cycle read latency. It makes at most one stack access per cycle. The stack grows toward lower addresses.

Top module: `rsave_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `stk_en` and `rf_wr_en` are low, the live word is zero and the stack pointer is zero.
- R2: An enter command (`cmd_op` = 2'b00) writes each register whose bit is set in both the live word and `cmd_mask`, one per cycle, in ascending index order. Each value goes to the next lower stack address: the first to `sp`-1, and so on downward.
- R3: After those registers, an enter command pushes the previous live word, zero-extended, as the last word. When the saved set is empty, this word is the only one pushed.
- R4: When an enter command completes, the live word equals the old live word ORed with the mask, and `sp` has dropped by the number of saved registers plus one.
- R5: A leave command (`cmd_op` = 2'b01) first pops the live word. It then pops registers in descending index order, one for each bit set in the popped word ANDed with `cmd_mask`, writes them to the register file, and sets the live word to the popped word.
- R6: A spill-all command (`cmd_op` = 2'b10) pushes every live register in ascending order and then the live word, and then sets the live word to zero.
- R7: A refill command (`cmd_op` = 2'b11) pops the live word, restores every register marked in it in descending order, and sets the live word to the popped word.
- R8: `busy` is high from the cycle after a command is accepted until the sequence ends. `done` then pulses for exactly one cycle, in the first cycle with `busy` low. A command presented while `busy` is high has no effect.
- R9: While idle with `track_en` high, a `trk_we` strobe sets bit `trk_idx` of the live word. With `track_en` low, the strobe has no effect. While idle and without a tracking strobe, the live word does not change.
- R10: A push sequence keeps `busy` high for N+1 cycles and a pop sequence for 2+2N cycles, where N is the number of registers moved.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted only while idle |
| cmd_op | input | 2 | 00 enter, 01 leave, 10 spill-all, 11 refill |
| cmd_mask | input | NREG | Callee needed-register mask (enter and leave) |
| track_en | input | 1 | Enables automatic live-bit tracking |
| trk_we | input | 1 | Core register-write strobe for tracking |
| trk_idx | input | log2(NREG) | Index of the register written by the core |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| live | output | NREG | Current live-register word |
| sp | output | SAW | Stack pointer, which addresses the top occupied word |
| rf_rd_idx | output | log2(NREG) | Register-file read index |
| rf_rd_data | input | XLEN | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | log2(NREG) | Register-file write index |
| rf_wr_data | output | XLEN | Register-file write data |
| stk_en | output | 1 | Stack memory access enable |
| stk_we | output | 1 | Stack write (1) or read (0) |
| stk_addr | output | SAW | Stack memory address |
| stk_wdata | output | XLEN | Stack write data |
| stk_rdata | input | XLEN | Stack read data, valid one cycle after the read |

## Verification
The bound checker checks the following on every cycle:
- the shape of the `done` pulse and its relation to `busy`;
- that the stack pointer moves by one word in the right direction on each push or pop;
- that no stack or register-file access happens outside a sequence;
- that the live word stays put while idle without a tracking strobe.

Only the bench scenarios can show that the right registers are moved, in the right order and with the right data. They also show the live word after nested enters and out-of-order masks, the restore of clobbered registers, the empty-set enter, the spill-all and refill pair, the per-sequence cycle counts, and that commands presented while busy are dropped.

// File: rtl/rsave_pkg.sv
package rsave_pkg;

    typedef enum logic [1:0] {
        OP_ENTER   = 2'b00,
        OP_LEAVE   = 2'b01,
        OP_SPILL   = 2'b10,
        OP_REFILL  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_REG,
        ST_PUSH_LIVE,
        ST_POP_LIVE_RD,
        ST_POP_LIVE_WB,
        ST_POP_REG_RD,
        ST_POP_REG_WB
    } state_e;

    // Per-command control carried through a sequence
    typedef struct packed {
        logic pop;       // sequence reads the stack
        logic wipe;      // live word becomes zero after the push
        logic full_set;  // mask is all ones instead of cmd_mask
    } ctl_t;

    function automatic ctl_t decode_op(input op_e op);
        ctl_t c;
        c.pop      = (op == OP_LEAVE) || (op == OP_REFILL);
        c.wipe     = (op == OP_SPILL);
        c.full_set = (op == OP_SPILL) || (op == OP_REFILL);
        return c;
    endfunction

endpackage

// File: rtl/rsave_prio.sv
module rsave_prio #(
    parameter int unsigned N          = 16,
    parameter bit          HIGH_FIRST = 1'b0,
    localparam int unsigned IW        = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx
);

    generate
        if (HIGH_FIRST) begin : g_high
            always_comb begin
                idx = '0;
                for (int i = 0; i < N; i++) begin
                    if (req[i]) idx = IW'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (req[i]) idx = IW'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rsave_live.sv
module rsave_live #(
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            idle,
    input  logic            track_en,
    input  logic            trk_we,
    input  logic [IW-1:0]   trk_idx,
    input  logic            load,
    input  logic [NREG-1:0] load_val,
    output logic [NREG-1:0] live
);

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (load) begin
            live <= load_val;
        end else if (idle && track_en && trk_we) begin
            live[trk_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/rsave_sp.sv
module rsave_sp #(
    parameter int unsigned SAW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic           pop,
    output logic [SAW-1:0] sp,
    output logic [SAW-1:0] sp_below
);

    assign sp_below = sp - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp_below;
        end else if (pop) begin
            sp <= sp + 1'b1;
        end
    end

endmodule

// File: rtl/rsave_seq.sv
module rsave_seq
    import rsave_pkg::*;
#(
    parameter int unsigned NREG = 16,
    parameter int unsigned XLEN = 32,
    parameter int unsigned SAW  = 8,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [NREG-1:0] cmd_mask,
    input  logic            track_en,
    input  logic            trk_we,
    input  logic [IW-1:0]   trk_idx,
    output logic            busy,
    output logic            done,
    output logic [NREG-1:0] live,
    output logic [SAW-1:0]  sp,
    output logic [IW-1:0]   rf_rd_idx,
    input  logic [XLEN-1:0] rf_rd_data,
    output logic            rf_wr_en,
    output logic [IW-1:0]   rf_wr_idx,
    output logic [XLEN-1:0] rf_wr_data,
    output logic            stk_en,
    output logic            stk_we,
    output logic [SAW-1:0]  stk_addr,
    output logic [XLEN-1:0] stk_wdata,
    input  logic [XLEN-1:0] stk_rdata
);

    state_e          state;
    ctl_t            ctl_q;
    ctl_t            ctl_in;
    logic [NREG-1:0] mask_q;
    logic [NREG-1:0] mask_eff;
    logic [NREG-1:0] rem_q;
    logic [NREG-1:0] saved_q;
    logic [IW-1:0]   idx_q;
    logic            done_q;

    logic [IW-1:0]   push_idx;
    logic [IW-1:0]   pop_idx;
    logic [NREG-1:0] rem_clr_push;
    logic [NREG-1:0] rem_clr_pop;
    logic [NREG-1:0] popped;
    logic [NREG-1:0] popped_sel;
    logic [SAW-1:0]  sp_below;
    logic            do_push;
    logic            do_pop;
    logic            live_ld;
    logic [NREG-1:0] live_ld_val;
    logic            idle;

    // ---------------- Command decode ----------------
    assign ctl_in   = decode_op(op_e'(cmd_op));
    assign mask_eff = ctl_in.full_set ? {NREG{1'b1}} : cmd_mask;
    assign idle     = (state == ST_IDLE);

    // ---------------- Register pickers ----------------
    rsave_prio #(.N(NREG), .HIGH_FIRST(1'b0)) u_pick_push (
        .req (rem_q),
        .idx (push_idx)
    );

    rsave_prio #(.N(NREG), .HIGH_FIRST(1'b1)) u_pick_pop (
        .req (rem_q),
        .idx (pop_idx)
    );

    assign rem_clr_push = rem_q & ~(NREG'(1) << push_idx);
    assign rem_clr_pop  = rem_q & ~(NREG'(1) << idx_q);
    assign popped       = stk_rdata[NREG-1:0];
    assign popped_sel   = popped & mask_q;

    // ---------------- Stack pointer ----------------
    assign do_push = (state == ST_PUSH_REG) || (state == ST_PUSH_LIVE);
    assign do_pop  = (state == ST_POP_LIVE_RD) || (state == ST_POP_REG_RD);

    rsave_sp #(.SAW(SAW)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .push     (do_push),
        .pop      (do_pop),
        .sp       (sp),
        .sp_below (sp_below)
    );

    // ---------------- Live word ----------------
    always_comb begin
        live_ld     = 1'b0;
        live_ld_val = saved_q;
        case (state)
            ST_PUSH_LIVE: begin
                live_ld     = 1'b1;
                live_ld_val = ctl_q.wipe ? '0 : (live | mask_q);
            end
            ST_POP_LIVE_WB: begin
                live_ld     = (popped_sel == '0);
                live_ld_val = popped;
            end
            ST_POP_REG_WB: begin
                live_ld     = (rem_clr_pop == '0);
                live_ld_val = saved_q;
            end
            default: begin
                live_ld     = 1'b0;
                live_ld_val = saved_q;
            end
        endcase
    end

    rsave_live #(.NREG(NREG)) u_live (
        .clk      (clk),
        .rst      (rst),
        .idle     (idle),
        .track_en (track_en),
        .trk_we   (trk_we),
        .trk_idx  (trk_idx),
        .load     (live_ld),
        .load_val (live_ld_val),
        .live     (live)
    );

    // ---------------- Sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl_q   <= '0;
            mask_q  <= '0;
            rem_q   <= '0;
            saved_q <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        ctl_q  <= ctl_in;
                        mask_q <= mask_eff;
                        rem_q  <= live & mask_eff;
                        if (ctl_in.pop)
                            state <= ST_POP_LIVE_RD;
                        else if ((live & mask_eff) != '0)
                            state <= ST_PUSH_REG;
                        else
                            state <= ST_PUSH_LIVE;
                    end
                end
                ST_PUSH_REG: begin
                    rem_q <= rem_clr_push;
                    if (rem_clr_push == '0) state <= ST_PUSH_LIVE;
                end
                ST_PUSH_LIVE: begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                ST_POP_LIVE_RD: begin
                    state <= ST_POP_LIVE_WB;
                end
                ST_POP_LIVE_WB: begin
                    saved_q <= popped;
                    rem_q   <= popped_sel;
                    if (popped_sel != '0) begin
                        state <= ST_POP_REG_RD;
                    end else begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                ST_POP_REG_RD: begin
                    idx_q <= pop_idx;
                    state <= ST_POP_REG_WB;
                end
                ST_POP_REG_WB: begin
                    rem_q <= rem_clr_pop;
                    if (rem_clr_pop == '0) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_POP_REG_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // ---------------- Port drive ----------------
    assign busy       = !idle;
    assign done       = done_q;
    assign rf_rd_idx  = push_idx;
    assign rf_wr_en   = (state == ST_POP_REG_WB);
    assign rf_wr_idx  = idx_q;
    assign rf_wr_data = stk_rdata;
    assign stk_en     = do_push || do_pop;
    assign stk_we     = do_push;
    assign stk_addr   = do_push ? sp_below : sp;
    assign stk_wdata  = (state == ST_PUSH_LIVE) ? XLEN'(live) : rf_rd_data;

endmodule

// File: rtl/rsave_seq_chk.sv
module rsave_seq_chk #(
    parameter int unsigned NREG = 16,
    parameter int unsigned SAW  = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            track_en,
    input logic            trk_we,
    input logic [NREG-1:0] live,
    input logic [SAW-1:0]  sp,
    input logic            stk_en,
    input logic            stk_we,
    input logic            rf_wr_en
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8
    access_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (stk_en || rf_wr_en) |-> busy);

    // R2
    push_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (stk_en && stk_we) |=> (sp == SAW'($past(sp) - 1'b1)));

    // R5
    pop_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (stk_en && !stk_we) |=> (sp == SAW'($past(sp) + 1'b1)));

    // R9
    live_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(track_en && trk_we)) |=> $stable(live));

endmodule

bind rsave_seq rsave_seq_chk #(.NREG(NREG), .SAW(SAW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .track_en (track_en),
    .trk_we   (trk_we),
    .live     (live),
    .sp       (sp),
    .stk_en   (stk_en),
    .stk_we   (stk_we),
    .rf_wr_en (rf_wr_en)
);

// File: tb/rsave_seq_bench.sv
module rsave_seq_bench;

    localparam int NREG  = 16;
    localparam int XLEN  = 32;
    localparam int SAW   = 8;
    localparam int IW    = 4;
    localparam int DEPTH = 256;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst;
    logic            cmd_valid;
    logic [1:0]      cmd_op;
    logic [NREG-1:0] cmd_mask;
    logic            track_en;
    logic            trk_we;
    logic [IW-1:0]   trk_idx;
    logic            busy, done;
    logic [NREG-1:0] live;
    logic [SAW-1:0]  sp;
    logic [IW-1:0]   rf_rd_idx;
    logic [XLEN-1:0] rf_rd_data;
    logic            rf_wr_en;
    logic [IW-1:0]   rf_wr_idx;
    logic [XLEN-1:0] rf_wr_data;
    logic            stk_en, stk_we;
    logic [SAW-1:0]  stk_addr;
    logic [XLEN-1:0] stk_wdata;
    logic [XLEN-1:0] stk_rdata;

    rsave_seq #(.NREG(NREG), .XLEN(XLEN), .SAW(SAW)) u_rsave_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .track_en(track_en), .trk_we(trk_we),
        .trk_idx(trk_idx), .busy(busy), .done(done), .live(live), .sp(sp),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .stk_en(stk_en),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .stk_rdata(stk_rdata)
    );

    // ---------------- Memory models ----------------
    logic [XLEN-1:0] rf_m  [NREG];
    logic [XLEN-1:0] stk_m [DEPTH];
    logic [XLEN-1:0] ex_mem [DEPTH];
    logic            bw_en;
    logic [IW-1:0]   bw_idx;
    logic [XLEN-1:0] bw_data;

    function automatic logic [XLEN-1:0] init_val(input int i);
        return 32'hA500_0000 + (i * 32'h0001_0203);
    endfunction

    assign rf_rd_data = rf_m[rf_rd_idx];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) rf_m[i] <= init_val(i);
        end else begin
            if (bw_en) rf_m[bw_idx] <= bw_data;
            if (rf_wr_en) rf_m[rf_wr_idx] <= rf_wr_data;
        end
        if (stk_en) begin
            if (stk_we) stk_m[stk_addr] <= stk_wdata;
            else        stk_rdata <= stk_m[stk_addr];
        end
    end

    // ---------------- Scoreboard ----------------
    typedef struct { logic [SAW-1:0] a; logic [XLEN-1:0] d; } wexp_t;
    typedef struct { logic [IW-1:0] i;  logic [XLEN-1:0] d; } rexp_t;
    wexp_t wq[$];
    rexp_t rq[$];

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (stk_en && stk_we) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R2/R3 unexpected stack write", 64'(stk_addr), 64'hFFFF);
                end else begin
                    wexp_t e;
                    e = wq.pop_front();
                    check(stk_addr == e.a, "R2/R3 push address", 64'(stk_addr), 64'(e.a));
                    check(stk_wdata == e.d, "R2/R3 push data", 64'(stk_wdata), 64'(e.d));
                end
            end
            if (rf_wr_en) begin
                if (rq.size() == 0) begin
                    check(1'b0, "R5/R7 unexpected restore", 64'(rf_wr_idx), 64'hFFFF);
                end else begin
                    rexp_t r;
                    r = rq.pop_front();
                    check(rf_wr_idx == r.i, "R5/R7 restore index", 64'(rf_wr_idx), 64'(r.i));
                    check(rf_wr_data == r.d, "R5/R7 restore data", 64'(rf_wr_data), 64'(r.d));
                end
            end
        end
    end

    // ---------------- Reference state ----------------
    logic [NREG-1:0] m_live;
    logic [SAW-1:0]  m_sp;

    task automatic clobber(input int idx, input logic [XLEN-1:0] val);
        @(negedge clk);
        bw_en = 1'b1; bw_idx = IW'(idx); bw_data = val;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [NREG-1:0] mask,
                          input bit poke, input string tag);
        logic [NREG-1:0] me, save, lw;
        int n, cnt, exp_cyc;
        me = op[1] ? {NREG{1'b1}} : mask;
        n = 0;
        if (!op[0]) begin
            save = m_live & me;
            for (int i = 0; i < NREG; i++) begin
                if (save[i]) begin
                    m_sp--;
                    wq.push_back('{m_sp, rf_m[i]});
                    ex_mem[m_sp] = rf_m[i];
                    n++;
                end
            end
            m_sp--;
            wq.push_back('{m_sp, XLEN'(m_live)});
            ex_mem[m_sp] = XLEN'(m_live);
            m_live  = op[1] ? '0 : (m_live | me);
            exp_cyc = n + 1;
        end else begin
            lw = ex_mem[m_sp][NREG-1:0];
            m_sp++;
            save = lw & me;
            for (int i = NREG - 1; i >= 0; i--) begin
                if (save[i]) begin
                    rq.push_back('{IW'(i), ex_mem[m_sp]});
                    m_sp++;
                    n++;
                end
            end
            m_live  = lw;
            exp_cyc = 2 + 2 * n;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mask = mask;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            if (poke && cnt == 1) begin
                // R8: a command while busy must be dropped
                cmd_valid = 1'b1; cmd_op = 2'b00; cmd_mask = '1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(cnt == exp_cyc, {tag, " R10 busy cycles"}, 64'(cnt), 64'(exp_cyc));
        check(done == 1'b1, {tag, " R8 done pulse"}, 64'(done), 64'd1);
        check(live == m_live, {tag, " live word"}, 64'(live), 64'(m_live));
        check(sp == m_sp, {tag, " stack pointer"}, 64'(sp), 64'(m_sp));
        @(negedge clk);
        check(done == 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'd0);
        check(wq.size() == 0 && rq.size() == 0, {tag, " scoreboard drained"},
              64'(wq.size() + rq.size()), 64'd0);
    endtask

    // ---------------- Watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- Stimulus ----------------
    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_mask = '0;
        track_en = 1'b0; trk_we = 1'b0; trk_idx = '0;
        bw_en = 1'b0; bw_idx = '0; bw_data = '0;
        m_live = '0; m_sp = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !stk_en && !rf_wr_en, "R1 control idle",
              64'({busy, done, stk_en, rf_wr_en}), 64'd0);
        check(live == '0 && sp == '0, "R1 live and sp zero", 64'({live, sp}), 64'd0);

        // R9 tracking sets bits 2, 5, 9
        track_en = 1'b1;
        foreach (m_live[k]) begin end
        trk_we = 1'b1; trk_idx = 4'd2; @(negedge clk);
        trk_idx = 4'd5; @(negedge clk);
        trk_idx = 4'd9; @(negedge clk);
        trk_we = 1'b0;
        m_live = 16'h0224;
        check(live == m_live, "R9 tracking sets bits", 64'(live), 64'(m_live));
        // R9 tracking disabled has no effect
        track_en = 1'b0; trk_we = 1'b1; trk_idx = 4'd3; @(negedge clk);
        trk_we = 1'b0; @(negedge clk);
        check(live == m_live, "R9 tracking off ignored", 64'(live), 64'(m_live));

        // R2 R3 R4 nested enters
        do_cmd(2'b00, 16'h0030, 1'b0, "R2/R4 enter A");
        do_cmd(2'b00, 16'h0F00, 1'b0, "R2/R4 enter B");
        clobber(9, 32'hDEAD_0009);
        clobber(5, 32'hDEAD_0005);
        clobber(8, 32'hDEAD_0008);
        // R5 leaves restore in reverse
        do_cmd(2'b01, 16'h0F00, 1'b0, "R5 leave B");
        check(rf_m[9] == init_val(9), "R5 r9 restored", 64'(rf_m[9]), 64'(init_val(9)));
        do_cmd(2'b01, 16'h0030, 1'b0, "R5 leave A");
        check(rf_m[5] == init_val(5), "R5 r5 restored", 64'(rf_m[5]), 64'(init_val(5)));

        // R3 empty saved set still pushes the live word
        do_cmd(2'b00, 16'h0001, 1'b0, "R3 empty enter");
        do_cmd(2'b01, 16'h0001, 1'b0, "R5 empty leave");

        // R6 spill-all with a command poked while busy (R8)
        do_cmd(2'b10, 16'h0000, 1'b1, "R6/R8 spill");
        clobber(2, 32'hBEEF_0002);
        clobber(9, 32'hBEEF_0009);
        // R7 refill
        do_cmd(2'b11, 16'h0000, 1'b1, "R7/R8 refill");
        check(rf_m[2] == init_val(2), "R7 r2 restored", 64'(rf_m[2]), 64'(init_val(2)));
        check(rf_m[9] == init_val(9), "R7 r9 restored", 64'(rf_m[9]), 64'(init_val(9)));

        // R6 R7 with nothing live
        m_live = live;
        do_cmd(2'b10, 16'h0000, 1'b0, "R6 spill live");
        do_cmd(2'b10, 16'h0000, 1'b0, "R6 spill empty");
        do_cmd(2'b11, 16'h0000, 1'b0, "R7 refill empty");
        do_cmd(2'b11, 16'h0000, 1'b0, "R7 refill live");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule